// File: doc/BRIEF.md
# Bit Set/Clear Control Register Bank

This block holds a small bank of control words. Each word is reached through three bus addresses: one that turns bits on, one that turns bits off, and one that returns the stored word. Software can flip a single control bit with one write and never reads the register first. A read-modify-write sequence would give an interrupt handler a window in which to overwrite a neighbouring bit, and this layout removes that window.

The bus is a plain synchronous register port with a byte address, a write strobe with 32-bit write data, and a read strobe. Read data comes back registered, one cycle after the strobe. Every stored word is also driven out continuously as a control vector for the peripheral logic around the bank. Bit i of the write data acts on bit i of the register, and bit 0 is the least significant bit of the little-endian data word.

Top module: `alias_reg_bank`

## Requirements
- R1: A synchronous active-low reset clears every register and the read data output to zero.
- R2: Writing to the set alias (byte offset 0 within a register's 16-byte slot) forces to one every register bit whose write-data bit is one.
- R3: Writing to the clear alias (byte offset 4 within the slot) forces to zero every register bit whose write-data bit is one.
- R4: A write-data bit of zero at the set or clear alias leaves the matching register bit unchanged.
- R5: A read strobe at the read alias (byte offset 8) returns the stored word on the read data output in the cycle after the strobe. The read data output is zero in any cycle that follows a cycle without a read strobe.
- R6: A read of the set alias or the clear alias returns zero. A write to the read alias changes nothing.
- R7: An access is unmapped, and its write is ignored and its read returns zero, when it uses byte offset 12, when the slot index (address bits above bit 3) is at or beyond the register count, or when either of address bits 1:0 is nonzero.
- R8: Register r drives control output bits r*32 to r*32+31 and takes its new value at the clock edge that takes the write.
- R9: A read and a write to the same register in one cycle return the value from before the write.
- R10: A write to one slot leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, which acts as the bit mask at the set and clear aliases |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ctrl_o | output | 128 | All registers side by side, register 0 in the low bits |

## Verification
The assertions assume that the strobes and the address are driven to known values in every cycle after reset. They also assume that a single address serves the write and the read of one cycle, so that only one alias of one slot is hit per cycle. The stimulus changes the inputs only at the falling edge and never leaves a strobe undefined. Alongside directed accesses to every alias, to misaligned addresses and to out-of-range slots, it issues random accesses whose address, data and strobes are all drawn from known values.

// File: rtl/alias_reg_pkg.sv
package alias_reg_pkg;
  // Word offset inside a 16-byte slot; decode depends on this order.
  typedef enum logic [1:0] {
    ALIAS_SET  = 2'd0,
    ALIAS_CLR  = 2'd1,
    ALIAS_READ = 2'd2,
    ALIAS_HOLE = 2'd3
  } alias_e;

  localparam int SLOT_BYTES_LOG2 = 4;
endpackage

// File: rtl/alias_decode.sv
module alias_decode
  import alias_reg_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic                rd,
  output logic [NUM_REGS-1:0] set_hit,
  output logic [NUM_REGS-1:0] clr_hit,
  output logic [NUM_REGS-1:0] rd_hit
);
  localparam int SLOT_W = ADDR_W - SLOT_BYTES_LOG2;

  logic [SLOT_W-1:0] slot;
  alias_e            kind;
  logic              aligned;

  assign slot    = addr[ADDR_W-1:SLOT_BYTES_LOG2];
  assign kind    = alias_e'(addr[3:2]);
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_slot
    logic mine;
    assign mine       = aligned && (slot == SLOT_W'(r));
    assign set_hit[r] = wr && mine && (kind == ALIAS_SET);
    assign clr_hit[r] = wr && mine && (kind == ALIAS_CLR);
    assign rd_hit[r]  = rd && mine && (kind == ALIAS_READ);
  end
endmodule

// File: rtl/alias_cell.sv
module alias_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (clr_en) nxt = nxt & ~mask;
    if (set_en) nxt = nxt | mask;   // set wins over clear
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R2: masked ones are present after a set
  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(mask)) == $past(mask)));
  // R3: masked bits are gone after a clear
  a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((q & $past(mask)) == '0));
  // R4: bits outside the mask keep their value
  a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en || clr_en) |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));
  // R10: no hit, no change
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/alias_rdmux.sv
module alias_rdmux #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32
) (
  input  logic [NUM_REGS*DATA_W-1:0] regs,
  input  logic [NUM_REGS-1:0]        sel,
  output logic [DATA_W-1:0]          dout
);
  always_comb begin
    dout = '0;
    for (int r = 0; r < NUM_REGS; r++)
      dout = dout | (regs[r*DATA_W +: DATA_W] & {DATA_W{sel[r]}});
  end
endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_rd,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [NUM_REGS*DATA_W-1:0] ctrl_o
);
  localparam int FLAT_W = NUM_REGS * DATA_W;

  logic [NUM_REGS-1:0] set_hit, clr_hit, rd_hit;
  logic [DATA_W-1:0]   rd_word;
  logic [FLAT_W-1:0]   regs_flat;

  alias_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .set_hit(set_hit), .clr_hit(clr_hit), .rd_hit(rd_hit)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    alias_cell #(.DATA_W(DATA_W)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .set_en(set_hit[r]), .clr_en(clr_hit[r]), .mask(bus_wdata),
      .q(regs_flat[r*DATA_W +: DATA_W])
    );
  end

  alias_rdmux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_mux (
    .regs(regs_flat), .sel(rd_hit), .dout(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_word;
  end

  assign ctrl_o = regs_flat;

  // R5: no strobe, zero data next cycle
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
  // R6: set or clear alias reads back as zero
  a_r6_alias_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr[3:2] != 2'd2)) |=> (bus_rdata == '0));
  // R6: a write to the read alias leaves the bank alone
  a_r6_read_alias_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr[3:2] == 2'd2)) |=> $stable(ctrl_o));
  // R7: hole offset and misaligned writes leave the bank alone
  a_r7_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && ((bus_addr[3:2] == 2'd3) || (bus_addr[1:0] != 2'b00))) |=> $stable(ctrl_o));
  // R10: at most one slot is written per cycle
  a_r10_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_hit | clr_hit));
endmodule

// File: tb/sim_alias_reg_bank.sv
module sim_alias_reg_bank;
  localparam int NR = 4;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [NR*DW-1:0] ctrl_o;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  alias_reg_bank #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ctrl_o(ctrl_o)
  );

  // Behavioural reference model
  logic [DW-1:0] m [NR];
  logic [DW-1:0] exp_rd;
  bit            model_live = 0;

  always @(posedge clk) begin
    int slot, ofs;
    bit ok;
    slot = int'(bus_addr) / 16;
    ofs  = (int'(bus_addr) % 16) / 4;
    ok   = (bus_addr[1:0] == 2'b00) && (slot < NR);
    model_live = 1;
    if (!rst_n) begin
      for (int r = 0; r < NR; r++) m[r] = '0;
      exp_rd = '0;
    end else begin
      exp_rd = '0;
      if (bus_rd && ok && ofs == 2) exp_rd = m[slot];
      if (bus_wr && ok && ofs == 0) m[slot] = m[slot] | bus_wdata;
      if (bus_wr && ok && ofs == 1) m[slot] = m[slot] & ~bus_wdata;
    end
  end

  task automatic compare();
    if (!model_live) return;
    for (int r = 0; r < NR; r++) begin
      checks++;
      if (ctrl_o[r*DW +: DW] !== m[r]) begin
        fails++;
        $display("FAIL %s reg%0d actual=%h expected=%h", tag, r, ctrl_o[r*DW +: DW], m[r]);
      end
    end
    checks++;
    if (bus_rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, bus_rdata, exp_rd);
    end
  endtask

  task automatic cyc(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d, input logic r);
    @(negedge clk);
    compare();
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_rd = r;
  endtask

  function automatic logic [AW-1:0] A(input int slot, input int ofs);
    return AW'(slot * 16 + ofs * 4);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1 reset
    tag = "R1";
    repeat (3) cyc('0, 1'b0, '0, 1'b0);
    rst_n = 1'b1;
    cyc(A(0, 2), 1'b0, '0, 1'b1);
    // R2 set, R8 output
    tag = "R2";
    cyc(A(0, 0), 1'b1, 32'h0000_00A5, 1'b0);
    cyc(A(0, 0), 1'b1, 32'h8000_000F, 1'b0);
    tag = "R8";
    cyc(A(0, 2), 1'b0, '0, 1'b1);
    // R3 clear, R4 zeros keep
    tag = "R3";
    cyc(A(0, 1), 1'b1, 32'h0000_0005, 1'b0);
    tag = "R4";
    cyc(A(0, 1), 1'b1, 32'h0000_0000, 1'b0);
    cyc(A(0, 0), 1'b1, 32'h0000_0000, 1'b1);
    // R5 read alias and idle
    tag = "R5";
    cyc(A(0, 2), 1'b0, '0, 1'b1);
    cyc(A(0, 2), 1'b0, '0, 1'b0);
    // R6 alias reads zero; write to read alias ignored
    tag = "R6";
    cyc(A(0, 0), 1'b0, '0, 1'b1);
    cyc(A(0, 1), 1'b0, '0, 1'b1);
    cyc(A(1, 2), 1'b1, 32'hFFFF_FFFF, 1'b0);
    cyc(A(1, 2), 1'b0, '0, 1'b1);
    // R7 unmapped
    tag = "R7";
    cyc(A(1, 3), 1'b1, 32'hFFFF_FFFF, 1'b1);
    cyc(A(5, 0), 1'b1, 32'hFFFF_FFFF, 1'b0);
    cyc(A(1, 0) | 8'h1, 1'b1, 32'hFFFF_FFFF, 1'b0);
    cyc(A(7, 2), 1'b0, '0, 1'b1);
    cyc(A(1, 2), 1'b0, '0, 1'b1);
    // R10 independent slots
    tag = "R10";
    cyc(A(3, 0), 1'b1, 32'h1234_5678, 1'b0);
    cyc(A(2, 0), 1'b1, 32'hF0F0_F0F0, 1'b0);
    cyc(A(3, 1), 1'b1, 32'hFFFF_0000, 1'b0);
    // R9 read and write together
    tag = "R9";
    cyc(A(2, 2), 1'b0, '0, 1'b0);
    bus_wr = 1'b0;
    cyc(A(2, 2), 1'b1, 32'h0000_FFFF, 1'b1);
    cyc(A(2, 2), 1'b0, '0, 1'b1);
    // random traffic
    tag = "R2";
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom_range(0, 7) * 4);
      if ($urandom_range(0, 15) == 0) ra = AW'($urandom);
      cyc(ra, 1'($urandom), $urandom, 1'($urandom));
    end
    // R1 reset mid-run
    tag = "R1";
    rst_n = 1'b0;
    cyc(A(0, 2), 1'b0, '0, 1'b1);
    cyc(A(0, 2), 1'b0, '0, 1'b1);
    rst_n = 1'b1;
    cyc(A(0, 2), 1'b0, '0, 1'b0);
    cyc(A(0, 2), 1'b0, '0, 1'b0);
    summary();
  end
endmodule